// File: doc/BRIEF.md
# Multiplexed Decade Display Scanner

This block walks through the decades of a multi-digit decimal counter one at a time. At each position it puts that decade's 4-bit BCD value on a shared data bus and raises one line of a one-hot digit-select bus. The pointer moves on each rising edge of the scan clock and starts from the most significant decade. It counts downward toward the units decade and then wraps back to the top. The decade values arrive as a packed input vector. The counter that produces them lives outside this block.

A mode input removes the units decade from the cycle, so the scan has one position fewer. Each output bus has its own enable. A disabled bus is shown as a cleared valid flag and an all-zero value, which stands in for high impedance. This lets the block share its buses with other drivers. The scan reset is separate from any counter reset and takes precedence over stepping.

Top module: `digit_scanner`

## Requirements
- R1: When `scan_rst` is high at a rising edge of `clk`, the pointer moves to the top decade (index NUM_DIGITS-1) whatever the other inputs are. This takes priority over stepping.
- R2: With `sel_oe` high, `sel_out` is one-hot. Bit k is high when decade k is selected, with k=0 the units decade and k=NUM_DIGITS-1 the most significant.
- R3: With `skip_units` low, each rising edge without reset moves the pointer from index k to k-1. From index 0 it wraps to NUM_DIGITS-1.
- R4: With `skip_units` high, the pointer goes from index 1 to NUM_DIGITS-1, so the cycle visits NUM_DIGITS-1 positions. If the pointer is at index 0 when this mode is active, the next edge also moves it to NUM_DIGITS-1.
- R5: With `data_oe` high, `bcd_out` equals bits [4k+3:4k] of `digits`, where k is the selected index. It follows changes on `digits` without waiting for a clock edge.
- R6: With `data_oe` low, `bcd_out` is 0 and `bcd_valid` is 0. With `data_oe` high, `bcd_valid` is 1.
- R7: With `sel_oe` low, `sel_out` is 0 and `sel_valid` is 0. With `sel_oe` high, `sel_valid` is 1. Each enable gates only its own bus.
- R8: The output enables have no effect on stepping. After both buses have been disabled for any number of edges, re-enabling them shows the position that R1, R3 and R4 predict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; the pointer steps on its rising edge |
| scan_rst | input | 1 | Synchronous active-high scan reset to the top decade |
| skip_units | input | 1 | Drops the units decade from the cycle |
| data_oe | input | 1 | Enable for the BCD data bus |
| sel_oe | input | 1 | Enable for the digit-select bus |
| digits | input | NUM_DIGITS*DIGIT_W | Packed decade values, units in the low nibble |
| bcd_out | output | DIGIT_W | Selected decade value, zero when disabled |
| bcd_valid | output | 1 | Data bus driven |
| sel_out | output | NUM_DIGITS | One-hot digit select, zero when disabled |
| sel_valid | output | 1 | Select bus driven |

## Verification
The bench builds the block with its default of five decades and 4-bit digits. At that size the bench can go around the whole scan cycle many times for every combination of the mode input and the two enables. Switching the mode while the pointer sits on the units decade, and resetting the scan in the middle of a cycle, are both easy to reach. The decade values change at every step, so the bench catches a data bus that picks up the wrong nibble or lags behind its inputs.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Index reached after one scan step. The lowest index visited is 1 when
  // the units decade is skipped, otherwise 0; below that the scan wraps.
  function automatic int next_index(input int cur, input logic skip, input int n);
    int floor_idx;
    floor_idx = skip ? 1 : 0;
    if (cur <= floor_idx) return n - 1;
    return cur - 1;
  endfunction

endpackage

// File: rtl/scan_pointer.sv
module scan_pointer #(
  parameter int NUM_DIGITS = 5,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk,
  input  logic             scan_rst,
  input  logic             skip_units,
  output logic [IDX_W-1:0] pos_q,
  output logic             wrap_evt
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

  logic [IDX_W-1:0] pos_d;

  always_comb begin
    pos_d = IDX_W'(scan_pkg::next_index(int'(pos_q), skip_units, NUM_DIGITS));
  end

  // A step that lands on the top decade without a reset is a wrap.
  assign wrap_evt = !scan_rst && (pos_d == TOP_IDX);

  always_ff @(posedge clk) begin
    if (scan_rst) pos_q <= TOP_IDX;
    else          pos_q <= pos_d;
  end
endmodule

// File: rtl/digit_mux.sv
module digit_mux #(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W = 4,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
  input  logic [IDX_W-1:0]              pos,
  output logic [DIGIT_W-1:0]            value,
  output logic [NUM_DIGITS-1:0]         onehot
);
  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (pos == IDX_W'(i)) value = digits[i*DIGIT_W +: DIGIT_W];
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dec
    assign onehot[g] = (pos == IDX_W'(g));
  end
endmodule

// File: rtl/bus_gate.sv
module bus_gate #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  input  logic         oe,
  output logic [W-1:0] dout,
  output logic         valid
);
  assign dout  = oe ? din : '0;
  assign valid = oe;
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner #(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W = 4,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input  logic                          clk,
  input  logic                          scan_rst,
  input  logic                          skip_units,
  input  logic                          data_oe,
  input  logic                          sel_oe,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits,
  output logic [DIGIT_W-1:0]            bcd_out,
  output logic                          bcd_valid,
  output logic [NUM_DIGITS-1:0]         sel_out,
  output logic                          sel_valid
);
  logic [IDX_W-1:0]      pos_q;
  logic                  wrap_evt;
  logic [DIGIT_W-1:0]    raw_value;
  logic [NUM_DIGITS-1:0] raw_sel;

  scan_pointer #(.NUM_DIGITS(NUM_DIGITS)) u_ptr (
    .clk(clk), .scan_rst(scan_rst), .skip_units(skip_units),
    .pos_q(pos_q), .wrap_evt(wrap_evt)
  );

  digit_mux #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_mux (
    .digits(digits), .pos(pos_q), .value(raw_value), .onehot(raw_sel)
  );

  bus_gate #(.W(DIGIT_W)) u_data_gate (
    .din(raw_value), .oe(data_oe), .dout(bcd_out), .valid(bcd_valid)
  );

  bus_gate #(.W(NUM_DIGITS)) u_sel_gate (
    .din(raw_sel), .oe(sel_oe), .dout(sel_out), .valid(sel_valid)
  );
endmodule

// File: rtl/digit_scanner_chk.sv
module digit_scanner_chk #(
  parameter int NUM_DIGITS = 5,
  parameter int DIGIT_W = 4,
  localparam int IDX_W = $clog2(NUM_DIGITS)
) (
  input logic                          clk,
  input logic                          scan_rst,
  input logic                          skip_units,
  input logic                          data_oe,
  input logic                          sel_oe,
  input logic [NUM_DIGITS*DIGIT_W-1:0] digits,
  input logic [DIGIT_W-1:0]            bcd_out,
  input logic                          bcd_valid,
  input logic [NUM_DIGITS-1:0]         sel_out,
  input logic                          sel_valid,
  input logic [IDX_W-1:0]              pos,
  input logic                          wrap_evt
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);
  localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

  // R1
  reset_to_top_chk: assert property (@(posedge clk)
    scan_rst |=> (pos == TOP_IDX));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (scan_rst)
    sel_oe |-> ($countones(sel_out) == 1));

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (scan_rst)
    (pos > ONE_IDX) |=> (pos == $past(pos) - ONE_IDX));

  // R3
  units_wrap_chk: assert property (@(posedge clk) disable iff (scan_rst)
    (!skip_units && pos == '0) |=> (pos == TOP_IDX));

  // R4
  skip_wrap_chk: assert property (@(posedge clk) disable iff (scan_rst)
    (skip_units && pos <= ONE_IDX) |=> (pos == TOP_IDX));

  // R3
  wrap_event_chk: assert property (@(posedge clk) disable iff (scan_rst)
    wrap_evt |=> (pos == TOP_IDX));

  // R6
  data_gate_chk: assert property (@(posedge clk) disable iff (scan_rst)
    !data_oe |-> (bcd_out == '0 && !bcd_valid));

  // R7
  sel_gate_chk: assert property (@(posedge clk) disable iff (scan_rst)
    !sel_oe |-> (sel_out == '0 && !sel_valid));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_data
    // R5
    data_match_chk: assert property (@(posedge clk) disable iff (scan_rst)
      (data_oe && sel_oe && sel_out[k]) |-> (bcd_out == digits[k*DIGIT_W +: DIGIT_W]));
  end
endmodule

bind digit_scanner digit_scanner_chk #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .scan_rst(scan_rst), .skip_units(skip_units), .data_oe(data_oe),
  .sel_oe(sel_oe), .digits(digits), .bcd_out(bcd_out), .bcd_valid(bcd_valid),
  .sel_out(sel_out), .sel_valid(sel_valid), .pos(pos_q), .wrap_evt(wrap_evt)
);

// File: tb/digit_scanner_tb.sv
`timescale 1ns/1ps
module digit_scanner_tb;
  localparam int N = 5;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           scan_rst, skip_units, data_oe, sel_oe;
  logic [N*W-1:0] digits;
  logic [W-1:0]   bcd_out;
  logic           bcd_valid;
  logic [N-1:0]   sel_out;
  logic           sel_valid;

  int checks = 0;
  int fails = 0;
  int exp_pos = N - 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  digit_scanner #(.NUM_DIGITS(N), .DIGIT_W(W)) u_dut (
    .clk(clk), .scan_rst(scan_rst), .skip_units(skip_units), .data_oe(data_oe),
    .sel_oe(sel_oe), .digits(digits), .bcd_out(bcd_out), .bcd_valid(bcd_valid),
    .sel_out(sel_out), .sel_valid(sel_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d pos=%0d t=%0t", req, act, exp, exp_pos, $time);
    end
  endtask

  task automatic load_digits(input int base);
    for (int k = 0; k < N; k++) digits[k*W +: W] = W'((base + 3*k + k*k) % 10);
  endtask

  // Edge, then update the reference position from the inputs held over it.
  task automatic tick();
    @(posedge clk);
    #1;
    if (scan_rst) exp_pos = N - 1;
    else if (exp_pos == 0 || (skip_units && exp_pos == 1)) exp_pos = N - 1;
    else exp_pos = exp_pos - 1;
  endtask

  task automatic check_all(input string tag);
    int exp_digit;
    exp_digit = (digits >> (exp_pos * W)) & 4'hF;
    chk({tag, " R5/R6 bcd_out"}, int'(bcd_out), data_oe ? exp_digit : 0);
    chk({tag, " R6 bcd_valid"}, int'(bcd_valid), int'(data_oe));
    chk({tag, " R2/R7 sel_out"}, int'(sel_out), sel_oe ? (1 << exp_pos) : 0);
    chk({tag, " R7 sel_valid"}, int'(sel_valid), int'(sel_oe));
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    scan_rst = 1; skip_units = 0; data_oe = 1; sel_oe = 1;
    load_digits(0);
    tick(); tick();
    check_all("R1 reset");
    scan_rst = 0;

    // Sweep every mode and enable combination over several full scans.
    for (int m = 0; m < 8; m++) begin
      skip_units = m[0]; data_oe = m[1]; sel_oe = m[2];
      for (int s = 0; s < 12; s++) begin
        load_digits(m * 13 + s);
        tick();
        check_all(skip_units ? "R4 sweep" : "R3 sweep");
        // R5: data follows the decade inputs without a clock edge
        load_digits(m * 7 + s + 4);
        #1;
        check_all("R5 live");
      end
    end

    // R4: mode switched on while the units decade is selected
    skip_units = 0; data_oe = 1; sel_oe = 1;
    while (exp_pos != 0) tick();
    check_all("R4 at units");
    skip_units = 1;
    tick();
    check_all("R4 units wrap");
    chk("R4 top after units", exp_pos, N - 1);

    // R1: reset in mid-scan overrides the step
    tick(); tick();
    scan_rst = 1;
    tick();
    check_all("R1 mid reset");
    scan_rst = 0;

    // R8: stepping continues while both buses are off
    skip_units = 0; data_oe = 0; sel_oe = 0;
    for (int s = 0; s < 7; s++) begin
      tick();
      check_all("R8 hidden");
    end
    data_oe = 1; sel_oe = 1;
    #1;
    check_all("R8 reenabled");

    report();
  end
endmodule